// File: doc/BRIEF.md
# Serial Line Register Interface

This block is the register front end of a serial line controller. A host reaches it through a simple word-addressed read/write bus with byte strobes. Four 16-bit registers sit at consecutive word addresses: receiver status (0), receiver buffer (1), transmitter status (2) and transmitter buffer (3). Behind the registers, the block exchanges single bytes with an external UART core. Incoming bytes arrive as one-cycle strobes with a format-error flag. Outgoing bytes leave as one-cycle strobes.

The block keeps the receive state: done, receiver active, overrun, framing and parity. It keeps the transmit state: ready, maintenance loopback and break. A parameterised counter stands in for the time one character needs on the line. In maintenance mode, a transmitted byte comes back into the receive path once that time has passed. Two interrupt requests are produced, one for receive and one for transmit. Each follows its done-and-enable condition and can be dismissed with an acknowledge pulse.

Top module: `serline_ctrl`

## Requirements
- R1: After reset, the receiver status and receiver buffer read 0x0000, and the transmitter status reads 0x0080 (ready). Both interrupt requests, the line break and the transmit strobe are low.
- R2: A byte strobed on the receive inputs appears in receiver buffer bits 7..0 on the next cycle. In the same update, receiver status bit 7 (done) is set and bit 11 (active) is cleared.
- R3: Any receiver buffer access clears done, whether a read or a write. The buffer contents cannot be written.
- R4: A receiver status write with byte strobe 0 does three things. It loads the interrupt enable from bit 6. It clears done when bit 0 is set. Bits 11 and 7 are left unaffected. Bit 0 always reads 0.
- R5: When a byte arrives while done is still set, receiver buffer bit 14 (overrun) is set. Every arriving byte clears the error flags and re-evaluates them.
- R6: A byte that arrives with a format error sets receiver buffer bits 13 and 12. Bit 15 is the OR of bits 14..12. All four error bits read 0 while the error-report strap is low.
- R7: A transmitter buffer write with byte strobe 0 starts a transmission. It emits the low byte with a one-cycle transmit strobe and clears ready (status bit 7). Ready is set again exactly CHAR_CYCLES cycles after the write.
- R8: With maintenance (transmitter status bit 2) set, a transmitter buffer write sets receiver active. CHAR_CYCLES cycles later, the byte is received with no error flags.
- R9: Transmitter status bit 0 (break) drives the line break output only while the break strap is high. The bit itself reads back regardless of the strap.
- R10: Receive requests are raised on the rising edge of done AND receive enable (status bit 6). Transmit requests are raised on the rising edge of ready AND transmit enable (status bit 6). A request rises one cycle after its condition rises and falls one cycle after its condition falls.
- R11: An acknowledge pulse drops its request while the condition stays high. The request is not raised again until the condition has fallen and risen again.
- R12: A write with byte strobe 0 low changes no control state and starts no transmission.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low bus reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word index; also selects read data when idle |
| bus_be | input | 2 | Byte write strobes |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data of the addressed register, combinational |
| rx_valid | input | 1 | Received byte strobe from the UART |
| rx_data | input | 8 | Received byte |
| rx_fmt_err | input | 1 | Received byte had a format error |
| tx_valid | output | 1 | Byte handed to the UART |
| tx_data | output | 8 | Byte to transmit |
| err_report_en | input | 1 | Strap: report error bits |
| brk_strap_en | input | 1 | Strap: allow line break |
| line_brk | output | 1 | Line break request |
| rx_ack | input | 1 | Receive request acknowledge |
| tx_ack | input | 1 | Transmit request acknowledge |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The hardest state to reach is an overrun whose error flags must be rebuilt on every byte. It only appears when arrivals and buffer reads interleave in the right order. A seeded random run covers it by randomly choosing, before each arrival, whether to read the buffer, while also varying the format flag and the report strap. A reference function predicts each buffer word from that history. The interrupt re-arm after an acknowledge is reached by a directed sequence: acknowledge while the condition holds, drop the condition through a buffer read, then raise it again with a new byte.

// File: rtl/serline_pkg.sv
package serline_pkg;
   localparam int CHAR_W = 8;

   typedef enum logic [1:0] {
      REG_RXSTAT = 2'd0,
      REG_RXBUF  = 2'd1,
      REG_TXSTAT = 2'd2,
      REG_TXBUF  = 2'd3
   } reg_sel_e;

   localparam int BIT_RX_ACT = 11;
   localparam int BIT_DONE   = 7;
   localparam int BIT_IE     = 6;
   localparam int BIT_RDR_EN = 0;
   localparam int BIT_ERR    = 15;
   localparam int BIT_OVR    = 14;
   localparam int BIT_FRM    = 13;
   localparam int BIT_PAR    = 12;
   localparam int BIT_RDY    = 7;
   localparam int BIT_MAINT  = 2;
   localparam int BIT_BRK    = 0;

   typedef struct packed {
      logic              valid;
      logic [CHAR_W-1:0] data;
      logic              fmt_err;
   } rx_evt_t;
endpackage

// File: rtl/serline_rx.sv
module serline_rx
   import serline_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  rx_evt_t           evt,
   input  logic              stat_wr,
   input  logic              stat_ie,
   input  logic              stat_rdr,
   input  logic              buf_acc,
   input  logic              set_active,
   output logic              done,
   output logic              active,
   output logic              ie,
   output logic              ovr,
   output logic              frm,
   output logic              par,
   output logic [CHAR_W-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done   <= 1'b0;
         active <= 1'b0;
         ie     <= 1'b0;
         ovr    <= 1'b0;
         frm    <= 1'b0;
         par    <= 1'b0;
         data   <= '0;
      end else begin
         if (set_active) active <= 1'b1;
         if (stat_wr) ie <= stat_ie;
         if (buf_acc || (stat_wr && stat_rdr)) done <= 1'b0;
         // a new byte outranks any clear in the same cycle
         if (evt.valid) begin
            ovr    <= done;
            frm    <= evt.fmt_err;
            par    <= evt.fmt_err;
            data   <= evt.data;
            done   <= 1'b1;
            active <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/serline_tx.sv
module serline_tx
   import serline_pkg::*;
#(
   parameter int CHAR_CYCLES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_wr,
   input  logic              stat_ie,
   input  logic              stat_maint,
   input  logic              stat_brk,
   input  logic              buf_wr,
   input  logic [CHAR_W-1:0] buf_wdata,
   output logic              ready,
   output logic              ie,
   output logic              maint,
   output logic              brk,
   output logic              tx_valid,
   output logic [CHAR_W-1:0] tx_data,
   output logic              lb_valid
);
   localparam int CNT_W = $clog2(CHAR_CYCLES);

   logic             busy;
   logic [CNT_W-1:0] cnt;

   // loopback delivery coincides with the end of the character time
   assign lb_valid = busy && (cnt == '0) && maint;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready    <= 1'b1;
         ie       <= 1'b0;
         maint    <= 1'b0;
         brk      <= 1'b0;
         tx_valid <= 1'b0;
         tx_data  <= '0;
         busy     <= 1'b0;
         cnt      <= '0;
      end else begin
         tx_valid <= 1'b0;
         if (stat_wr) begin
            ie    <= stat_ie;
            maint <= stat_maint;
            brk   <= stat_brk;
         end
         if (busy) begin
            if (cnt == '0) begin
               busy  <= 1'b0;
               ready <= 1'b1;
            end else begin
               cnt <= cnt - CNT_W'(1);
            end
         end
         if (buf_wr) begin
            tx_data  <= buf_wdata;
            tx_valid <= 1'b1;
            ready    <= 1'b0;
            busy     <= 1'b1;
            cnt      <= CNT_W'(CHAR_CYCLES - 1);
         end
      end
   end
endmodule

// File: rtl/serline_irq.sv
module serline_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic cond,
   input  logic ack,
   output logic req
);
   logic cond_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_q <= 1'b0;
         req    <= 1'b0;
      end else begin
         cond_q <= cond;
         if (cond && !cond_q) req <= 1'b1;
         else if (!cond || ack) req <= 1'b0;
      end
   end
endmodule

// File: rtl/serline_ctrl.sv
module serline_ctrl
   import serline_pkg::*;
#(
   parameter int REG_W       = 16,
   parameter int CHAR_CYCLES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [1:0]        bus_be,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic              rx_fmt_err,
   output logic              tx_valid,
   output logic [CHAR_W-1:0] tx_data,
   input  logic              err_report_en,
   input  logic              brk_strap_en,
   output logic              line_brk,
   input  logic              rx_ack,
   input  logic              tx_ack,
   output logic              rx_irq,
   output logic              tx_irq
);
   localparam int N_IRQ = 2;

   if (REG_W < 16) begin : g_bad_width
      $error("serline_ctrl: REG_W must be at least 16");
   end
   if (CHAR_CYCLES < 2) begin : g_bad_char
      $error("serline_ctrl: CHAR_CYCLES must be at least 2");
   end

   reg_sel_e sel_reg;
   logic     wr_lo;
   assign sel_reg = reg_sel_e'(bus_addr);
   assign wr_lo   = bus_sel && bus_wr && bus_be[0];

   logic rx_done_w, rx_act_w, rx_ie_w, rx_ovr_w, rx_frm_w, rx_par_w;
   logic [CHAR_W-1:0] rx_buf_w;
   logic tx_rdy_w, tx_ie_w, tx_maint_w, tx_brk_w, lb_w;
   logic tx_buf_wr;
   rx_evt_t rx_evt;
   logic rx_evt_w;

   assign tx_buf_wr = wr_lo && (sel_reg == REG_TXBUF);

   always_comb begin
      if (lb_w) rx_evt = '{valid: 1'b1, data: tx_data, fmt_err: 1'b0};
      else      rx_evt = '{valid: rx_valid, data: rx_data, fmt_err: rx_fmt_err};
   end
   assign rx_evt_w = rx_evt.valid;

   serline_rx u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (rx_evt),
      .stat_wr    (wr_lo && (sel_reg == REG_RXSTAT)),
      .stat_ie    (bus_wdata[BIT_IE]),
      .stat_rdr   (bus_wdata[BIT_RDR_EN]),
      .buf_acc    (bus_sel && (sel_reg == REG_RXBUF)),
      .set_active (tx_buf_wr && tx_maint_w),
      .done       (rx_done_w),
      .active     (rx_act_w),
      .ie         (rx_ie_w),
      .ovr        (rx_ovr_w),
      .frm        (rx_frm_w),
      .par        (rx_par_w),
      .data       (rx_buf_w)
   );

   serline_tx #(.CHAR_CYCLES(CHAR_CYCLES)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .stat_wr    (wr_lo && (sel_reg == REG_TXSTAT)),
      .stat_ie    (bus_wdata[BIT_IE]),
      .stat_maint (bus_wdata[BIT_MAINT]),
      .stat_brk   (bus_wdata[BIT_BRK]),
      .buf_wr     (tx_buf_wr),
      .buf_wdata  (bus_wdata[CHAR_W-1:0]),
      .ready      (tx_rdy_w),
      .ie         (tx_ie_w),
      .maint      (tx_maint_w),
      .brk        (tx_brk_w),
      .tx_valid   (tx_valid),
      .tx_data    (tx_data),
      .lb_valid   (lb_w)
   );

   logic [N_IRQ-1:0] irq_cond, irq_ack, irq_req;
   assign irq_cond = {tx_rdy_w && tx_ie_w, rx_done_w && rx_ie_w};
   assign irq_ack  = {tx_ack, rx_ack};

   for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
      serline_irq u_irq (
         .clk   (clk),
         .rst_n (rst_n),
         .cond  (irq_cond[g]),
         .ack   (irq_ack[g]),
         .req   (irq_req[g])
      );
   end
   assign rx_irq = irq_req[0];
   assign tx_irq = irq_req[1];

   assign line_brk = tx_brk_w && brk_strap_en;

   always_comb begin
      bus_rdata = '0;
      unique case (sel_reg)
         REG_RXSTAT: begin
            bus_rdata[BIT_RX_ACT] = rx_act_w;
            bus_rdata[BIT_DONE]   = rx_done_w;
            bus_rdata[BIT_IE]     = rx_ie_w;
         end
         REG_RXBUF: begin
            bus_rdata[CHAR_W-1:0] = rx_buf_w;
            if (err_report_en) begin
               bus_rdata[BIT_OVR] = rx_ovr_w;
               bus_rdata[BIT_FRM] = rx_frm_w;
               bus_rdata[BIT_PAR] = rx_par_w;
               bus_rdata[BIT_ERR] = rx_ovr_w || rx_frm_w || rx_par_w;
            end
         end
         REG_TXSTAT: begin
            bus_rdata[BIT_RDY]   = tx_rdy_w;
            bus_rdata[BIT_IE]    = tx_ie_w;
            bus_rdata[BIT_MAINT] = tx_maint_w;
            bus_rdata[BIT_BRK]   = tx_brk_w;
         end
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/serline_ctrl_chk.sv
module serline_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_sel,
   input logic       bus_wr,
   input logic [1:0] bus_addr,
   input logic [1:0] bus_be,
   input logic       brk_strap_en,
   input logic       line_brk,
   input logic       rx_irq,
   input logic       tx_irq,
   input logic       rx_done_w,
   input logic       rx_ie_w,
   input logic       tx_rdy_w,
   input logic       tx_ie_w,
   input logic       rx_evt_w,
   input logic       rx_ovr_w
);
   AST_RX_REQ_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> $past(rx_done_w && rx_ie_w)); // R10
   AST_TX_REQ_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> $past(tx_rdy_w && tx_ie_w)); // R10
   AST_RXBUF_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_addr == 2'd1 && !rx_evt_w) |=> !rx_done_w); // R3
   AST_TXBUF_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_be[0] && bus_addr == 2'd3) |=> !tx_rdy_w); // R7
   AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_evt_w && rx_done_w) |=> rx_ovr_w); // R5
   AST_BREAK_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !brk_strap_en |-> !line_brk); // R9
endmodule

bind serline_ctrl serline_ctrl_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_sel      (bus_sel),
   .bus_wr       (bus_wr),
   .bus_addr     (bus_addr),
   .bus_be       (bus_be),
   .brk_strap_en (brk_strap_en),
   .line_brk     (line_brk),
   .rx_irq       (rx_irq),
   .tx_irq       (tx_irq),
   .rx_done_w    (rx_done_w),
   .rx_ie_w      (rx_ie_w),
   .tx_rdy_w     (tx_rdy_w),
   .tx_ie_w      (tx_ie_w),
   .rx_evt_w     (rx_evt_w),
   .rx_ovr_w     (rx_ovr_w)
);

// File: tb/serline_ctrl_tb.sv
module serline_ctrl_tb_top;
   localparam int CT = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0, bus_be = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        rx_valid = 1'b0, rx_fmt_err = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        err_report_en = 1'b1, brk_strap_en = 1'b1;
   logic        line_brk, rx_ack = 1'b0, tx_ack = 1'b0, rx_irq, tx_irq;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   serline_ctrl #(.REG_W(16), .CHAR_CYCLES(CT)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_fmt_err(rx_fmt_err), .tx_valid(tx_valid), .tx_data(tx_data),
      .err_report_en(err_report_en), .brk_strap_en(brk_strap_en),
      .line_brk(line_brk), .rx_ack(rx_ack), .tx_ack(tx_ack),
      .rx_irq(rx_irq), .tx_irq(tx_irq)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic peek(input logic [1:0] a, output logic [15:0] v);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      step();
      bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [15:0] v);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 v = bus_rdata;
      step();
      bus_sel = 1'b0;
   endtask

   task automatic rx_byte(input logic [7:0] b, input logic f);
      rx_valid = 1'b1; rx_data = b; rx_fmt_err = f;
      step();
      rx_valid = 1'b0; rx_fmt_err = 1'b0;
   endtask

   function automatic logic [15:0] exp_rbuf(input logic [7:0] b, input logic ovr,
                                            input logic fmt, input logic en);
      logic [15:0] r;
      r = {8'h00, b};
      if (en) begin
         r[14] = ovr; r[13] = fmt; r[12] = fmt;
         r[15] = ovr | fmt;
      end
      return r;
   endfunction

   initial begin
      #1_000_000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      logic        m_done;
      void'($urandom(32'd4711));
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      peek(2'd0, v); check("R1 rxstat", v, 16'h0000);
      peek(2'd1, v); check("R1 rxbuf", v, 16'h0000);
      peek(2'd2, v); check("R1 txstat", v, 16'h0080);
      check("R1 outputs", {12'h0, rx_irq, tx_irq, line_brk, tx_valid}, 16'h0000);

      // R2 receive
      rx_byte(8'hA5, 1'b0);
      peek(2'd0, v); check("R2 done", v, 16'h0080);
      peek(2'd1, v); check("R2 data", v, 16'h00A5);

      // R3 read and write of buffer clear done
      bus_read(2'd1, v); check("R3 read value", v, 16'h00A5);
      peek(2'd0, v); check("R3 read clears", v, 16'h0000);
      rx_byte(8'h3C, 1'b0);
      bus_write(2'd1, 16'hFFFF, 2'b11);
      peek(2'd0, v); check("R3 write clears", v, 16'h0000);
      peek(2'd1, v); check("R3 read-only", v, 16'h003C);

      // R4 status write
      rx_byte(8'h11, 1'b0);
      bus_write(2'd0, 16'h08C1, 2'b01);
      peek(2'd0, v); check("R4 rdr clears done", v, 16'h0040);
      bus_write(2'd0, 16'h0000, 2'b01);
      rx_byte(8'h22, 1'b0);
      bus_write(2'd0, 16'h0000, 2'b01);
      peek(2'd0, v); check("R4 no rdr keeps done", v, 16'h0080);
      bus_read(2'd1, v);

      // R5 overrun
      rx_byte(8'h33, 1'b0);
      rx_byte(8'h44, 1'b0);
      peek(2'd1, v); check("R5 overrun", v, 16'hC044);
      bus_read(2'd1, v);
      rx_byte(8'h55, 1'b0);
      peek(2'd1, v); check("R5 re-evaluated", v, 16'h0055);
      bus_read(2'd1, v);

      // R6 format error and reporting strap
      rx_byte(8'h66, 1'b1);
      peek(2'd1, v); check("R6 format error", v, 16'hB066);
      err_report_en = 1'b0;
      peek(2'd1, v); check("R6 strap low", v, 16'h0066);
      err_report_en = 1'b1;
      bus_read(2'd1, v);

      // R12 byte strobe low
      bus_write(2'd0, 16'h0041, 2'b10);
      peek(2'd0, v); check("R12 rxstat untouched", v, 16'h0000);
      bus_write(2'd3, 16'h0077, 2'b10);
      check("R12 no tx strobe", {15'h0, tx_valid}, 16'h0000);
      peek(2'd2, v); check("R12 ready kept", v, 16'h0080);

      // R7 transmit timing
      bus_write(2'd3, 16'h01C3, 2'b11);
      check("R7 tx strobe", {7'h0, tx_valid, tx_data}, 16'h01C3);
      peek(2'd2, v); check("R7 ready cleared", v, 16'h0000);
      step();
      check("R7 strobe single", {15'h0, tx_valid}, 16'h0000);
      repeat (CT - 2) step();
      peek(2'd2, v); check("R7 still busy", v, 16'h0000);
      step();
      peek(2'd2, v); check("R7 ready back", v, 16'h0080);

      // R8 maintenance loopback
      bus_write(2'd2, 16'h0004, 2'b01);
      bus_write(2'd3, 16'h005A, 2'b01);
      peek(2'd0, v); check("R8 active", v, 16'h0800);
      repeat (CT - 1) step();
      peek(2'd0, v); check("R8 not yet", v, 16'h0800);
      step();
      peek(2'd0, v); check("R8 delivered", v, 16'h0080);
      peek(2'd1, v); check("R8 data", v, 16'h005A);
      peek(2'd2, v); check("R8 txstat", v, 16'h0084);
      bus_write(2'd2, 16'h0000, 2'b01);
      bus_read(2'd1, v);

      // R9 break
      bus_write(2'd2, 16'h0001, 2'b01);
      check("R9 break on", {15'h0, line_brk}, 16'h0001);
      peek(2'd2, v); check("R9 readback", v, 16'h0081);
      brk_strap_en = 1'b0;
      #1 check("R9 strap low", {15'h0, line_brk}, 16'h0000);
      brk_strap_en = 1'b1;
      #1 check("R9 strap high", {15'h0, line_brk}, 16'h0001);
      bus_write(2'd2, 16'h0000, 2'b01);

      // R10 / R11 receive request
      rx_byte(8'h10, 1'b0);
      bus_write(2'd0, 16'h0040, 2'b01);
      check("R10 rx not yet", {15'h0, rx_irq}, 16'h0000);
      step();
      check("R10 rx raised", {15'h0, rx_irq}, 16'h0001);
      rx_ack = 1'b1; step(); rx_ack = 1'b0;
      check("R11 ack drops", {15'h0, rx_irq}, 16'h0000);
      step();
      check("R11 stays low", {15'h0, rx_irq}, 16'h0000);
      bus_read(2'd1, v);
      rx_byte(8'h20, 1'b0);
      step();
      check("R11 rearmed", {15'h0, rx_irq}, 16'h0001);
      bus_read(2'd1, v);
      check("R10 rx held one cycle", {15'h0, rx_irq}, 16'h0001);
      step();
      check("R10 rx withdrawn", {15'h0, rx_irq}, 16'h0000);
      bus_write(2'd0, 16'h0000, 2'b01);

      // R10 transmit request
      bus_write(2'd2, 16'h0040, 2'b01);
      step();
      check("R10 tx raised", {15'h0, tx_irq}, 16'h0001);
      bus_write(2'd3, 16'h0001, 2'b01);
      step();
      check("R10 tx withdrawn", {15'h0, tx_irq}, 16'h0000);
      repeat (CT - 1) step();
      peek(2'd2, v); check("R7 ready with ie", v, 16'h00C0);
      check("R10 tx one cycle late", {15'h0, tx_irq}, 16'h0000);
      step();
      check("R10 tx again", {15'h0, tx_irq}, 16'h0001);
      bus_write(2'd2, 16'h0000, 2'b01);
      step();
      check("R10 tx off", {15'h0, tx_irq}, 16'h0000);

      // R2 R5 R6 random arrivals
      m_done = 1'b0;
      for (int i = 0; i < 150; i++) begin
         logic [7:0] b;
         logic f, e;
         if ($urandom % 2 == 0) begin
            bus_read(2'd1, v);
            m_done = 1'b0;
         end
         b = 8'($urandom);
         f = ($urandom % 4) == 0;
         e = 1'($urandom);
         err_report_en = e;
         rx_byte(b, f);
         peek(2'd1, v);
         check("R5 R6 random rxbuf", v, exp_rbuf(b, m_done, f, e));
         m_done = 1'b1;
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule